// File: doc/BRIEF.md
# TDM Timeslot Selector for Rate Adaptation

This block sits in front of the write port of a transmit elastic store. It turns a 32-timeslot system-side frame into the 24 channels of a T1 frame. Bytes arrive one at a time with a strobe. A frame-start flag marks the first timeslot. A 32-bit blanking mask names the incoming timeslots to throw away. The timeslots that are not blanked are packed, in arrival order, into output channels 0 to 23. Each one becomes a single write that carries a channel index and a data byte.

The mask is a register with its own write port. It resets to a setting that blanks the upper eight timeslots, so timeslots 0 to 23 pass straight through to channels 0 to 23. A new mask value waits in that register until the next frame-start byte. The block then takes it as the mask for the whole frame.

A mask can leave more or fewer than 24 live timeslots. With more, the surplus is dropped and an overflow flag is set. With fewer, the channels left unused are written with all-ones bytes, and an underflow flag is set. Each fill write is placed in the cycle of a blanked timeslot, so the block never issues more than one write per input byte. Bit serialisation, clock generation and the T1 framing bit are handled elsewhere.

Top module: `tslot_pack`

## Requirements
- R1: After reset `out_valid`, `ovf_flag` and `unf_flag` are 0. The mask register holds 32'hFF00_0000, which blanks timeslots 24..31. Timeslots 0..23 of the first frame therefore go to channels 0..23 in order, with unchanged data, and both flags stay 0.
- R2: A valid byte with `in_fstart`=1 is timeslot 0. Each later valid byte without `in_fstart` is the next timeslot, up to 31. Valid bytes that arrive before the first frame start, or after timeslot 31 of a frame, produce no write.
- R3: Bit i of the active mask equal to 1 means the byte of timeslot i is never written as data.
- R4: Unblanked timeslots take output channels 0, 1, 2, ... in arrival order. The count restarts at every frame-start byte. Each write appears on `out_valid`/`out_chan`/`out_data` on the clock after its input byte, and `out_data` is that byte.
- R5: A write to the mask register takes effect at the first frame-start byte after the write cycle. That value then applies to every timeslot of the frame, including timeslot 0. A write during a frame does not change that frame.
- R6: If the frame's mask leaves more than 24 timeslots unblanked, those beyond the 24th produce no write. `ovf_flag` is 1 from the clock after that frame's start byte until the next frame start.
- R7: If the mask leaves k < 24 timeslots unblanked, channels k..23 are written with 8'hFF in ascending order. One fill write goes out on each blanked timeslot, in arrival order, until all are filled. `unf_flag` is 1 over that frame.
- R8: With exactly 24 unblanked timeslots both flags are 0. The two flags are never 1 together, and they change only on the clock after a frame-start byte.
- R9: `out_chan` is always below 24 when `out_valid` is 1, and there is at most one write per accepted input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_fstart | input | 1 | Marks the strobed byte as timeslot 0 |
| in_data | input | 8 | Input timeslot byte |
| mask_we | input | 1 | Write enable of the blanking mask register |
| mask_wdata | input | 32 | New mask; bit i = 1 blanks timeslot i |
| out_valid | output | 1 | Write strobe toward the elastic store |
| out_chan | output | 5 | Output channel index, 0..23 |
| out_data | output | 8 | Byte to write |
| ovf_flag | output | 1 | Current frame has more than 24 live timeslots |
| unf_flag | output | 1 | Current frame has fewer than 24 live timeslots |

## Verification
The assertions hold on every cycle for any stimulus. They check that channel indices stay in range and that each write follows an input byte. They check that written data is either the input byte or the fill value, and that the flags are mutually exclusive and move only after a frame start. Only the bench scenarios can show the exact channel sequence a given mask produces. They also cover how fill writes are placed, that a mid-frame mask write is deferred, and that bytes before synchronisation or beyond timeslot 31 are dropped. The bench compares those scenarios, for a table of masks and for random ones, against a reference model.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int SLOTS  = 32;
    localparam int CHANS  = 24;
    localparam int BYTE_W = 8;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CHAN_W = $clog2(CHANS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    localparam logic [SLOTS-1:0]  DEFAULT_MASK = {{(SLOTS-CHANS){1'b1}}, {CHANS{1'b0}}};
    localparam logic [BYTE_W-1:0] FILL_BYTE    = {BYTE_W{1'b1}};

    // Per-byte descriptor handed from the timeslot tracker to the allocator
    typedef struct packed {
        logic              ok;
        logic              first;
        logic [SLOT_W-1:0] slot;
        logic              blanked;
        logic [CNT_W-1:0]  live;
        logic [BYTE_W-1:0] data;
    } slot_info_t;

    // One write toward the elastic store
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [BYTE_W-1:0] data;
    } wr_t;

    // Number of timeslots left unblanked by a mask
    function automatic logic [CNT_W-1:0] live_count(input logic [SLOTS-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < SLOTS; i++) begin
            n = n + CNT_W'(~m[i]);
        end
        return n;
    endfunction

    // Channels that must be filled when too few timeslots survive
    function automatic logic [CNT_W-1:0] fill_needed(input logic [CNT_W-1:0] live);
        return (live < CNT_W'(CHANS)) ? (CNT_W'(CHANS) - live) : '0;
    endfunction

endpackage

// File: rtl/tsp_slot_track.sv
module tsp_slot_track
    import tsp_pkg::*;
#(
    parameter logic [SLOTS-1:0] RESET_MASK = DEFAULT_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fstart,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              mask_we,
    input  logic [SLOTS-1:0]  mask_wdata,
    output slot_info_t        info,
    output logic              ovf_flag,
    output logic              unf_flag
);

    logic [SLOTS-1:0] pend_q;
    logic [SLOTS-1:0] act_q;
    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] slot_q;
    logic             synced_q;
    logic             ovf_q;
    logic             unf_q;

    logic             first;
    logic             cont;
    logic [SLOTS-1:0] frame_mask;
    logic [CNT_W-1:0] pend_live;

    always_comb begin
        pend_live  = live_count(pend_q);
        first      = in_valid && in_fstart;
        cont       = in_valid && !in_fstart && synced_q && (slot_q < CNT_W'(SLOTS));
        frame_mask = first ? pend_q : act_q;

        info.ok      = first || cont;
        info.first   = first;
        info.slot    = first ? '0 : slot_q[SLOT_W-1:0];
        info.blanked = frame_mask[info.slot];
        info.live    = first ? pend_live : live_q;
        info.data    = in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= RESET_MASK;
            act_q    <= RESET_MASK;
            live_q   <= live_count(RESET_MASK);
            slot_q   <= '0;
            synced_q <= 1'b0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            if (mask_we) begin
                pend_q <= mask_wdata;
            end
            if (first) begin
                act_q    <= pend_q;
                live_q   <= pend_live;
                slot_q   <= CNT_W'(1);
                synced_q <= 1'b1;
                ovf_q    <= pend_live > CNT_W'(CHANS);
                unf_q    <= pend_live < CNT_W'(CHANS);
            end else if (cont) begin
                slot_q <= slot_q + CNT_W'(1);
            end
        end
    end

    assign ovf_flag = ovf_q;
    assign unf_flag = unf_q;

endmodule

// File: rtl/tsp_chan_alloc.sv
module tsp_chan_alloc
    import tsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_info_t info,
    output wr_t        wr
);

    logic [CNT_W-1:0] chan_q;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] chan_cur;
    logic [CNT_W-1:0] fill_cur;
    logic [CNT_W-1:0] chan_nxt;
    logic [CNT_W-1:0] fill_nxt;
    logic [CNT_W-1:0] fill_chan;
    logic [CNT_W-1:0] need;

    always_comb begin
        chan_cur  = info.first ? '0 : chan_q;
        fill_cur  = info.first ? '0 : fill_q;
        need      = fill_needed(info.live);
        fill_chan = info.live + fill_cur;
        chan_nxt  = chan_cur;
        fill_nxt  = fill_cur;
        wr        = '0;
        if (info.ok) begin
            if (!info.blanked) begin
                if (chan_cur < CNT_W'(CHANS)) begin
                    wr.valid = 1'b1;
                    wr.chan  = chan_cur[CHAN_W-1:0];
                    wr.data  = info.data;
                    chan_nxt = chan_cur + CNT_W'(1);
                end
            end else if (fill_cur < need) begin
                wr.valid = 1'b1;
                wr.chan  = fill_chan[CHAN_W-1:0];
                wr.data  = FILL_BYTE;
                fill_nxt = fill_cur + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            fill_q <= '0;
        end else if (info.ok) begin
            chan_q <= chan_nxt;
            fill_q <= fill_nxt;
        end
    end

endmodule

// File: rtl/tsp_out_reg.sv
module tsp_out_reg
    import tsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  wr_t  wr_d,
    output wr_t  wr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

endmodule

// File: rtl/tslot_pack.sv
module tslot_pack
    import tsp_pkg::*;
#(
    parameter logic [SLOTS-1:0] RESET_MASK = DEFAULT_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_fstart,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              mask_we,
    input  logic [SLOTS-1:0]  mask_wdata,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic [BYTE_W-1:0] out_data,
    output logic              ovf_flag,
    output logic              unf_flag
);

    slot_info_t info;
    wr_t        wr_d;
    wr_t        wr_q;

    tsp_slot_track #(.RESET_MASK(RESET_MASK)) u_track (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_fstart  (in_fstart),
        .in_data    (in_data),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .info       (info),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag)
    );

    tsp_chan_alloc u_alloc (
        .clk  (clk),
        .rst  (rst),
        .info (info),
        .wr   (wr_d)
    );

    tsp_out_reg u_oreg (
        .clk  (clk),
        .rst  (rst),
        .wr_d (wr_d),
        .wr_q (wr_q)
    );

    assign out_valid = wr_q.valid;
    assign out_chan  = wr_q.chan;
    assign out_data  = wr_q.data;

endmodule

// File: rtl/tslot_pack_chk.sv
module tslot_pack_chk
    import tsp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_fstart,
    input logic [BYTE_W-1:0] in_data,
    input logic              out_valid,
    input logic [CHAN_W-1:0] out_chan,
    input logic [BYTE_W-1:0] out_data,
    input logic              ovf_flag,
    input logic              unf_flag
);

    p_chan_range_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chan < CHAN_W'(CHANS)));

    p_write_after_byte_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R4 / R7: written data is either the input byte or the fill value
    p_data_source_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_data != $past(in_data))) |-> (out_data == FILL_BYTE));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(ovf_flag && unf_flag));

    p_flags_frame_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid && in_fstart) |-> ($stable(ovf_flag) && $stable(unf_flag)));

endmodule

bind tslot_pack tslot_pack_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_fstart (in_fstart),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/tslot_pack_bench.sv
module tslot_pack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {mask, expected ovf, expected unf}
    localparam logic [33:0] VEC [NVEC] = '{
        {32'hFF00_0000, 1'b0, 1'b0},
        {32'h0000_00FF, 1'b0, 1'b0},
        {32'hAAAA_0000, 1'b0, 1'b0},
        {32'h0000_0000, 1'b1, 1'b0},
        {32'hFFFF_0000, 1'b0, 1'b1},
        {32'hFFFF_FFFF, 1'b0, 1'b1},
        {32'h8000_0001, 1'b1, 1'b0},
        {32'h5555_FF00, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_fstart;
    logic [7:0]  in_data;
    logic        mask_we;
    logic [31:0] mask_wdata;
    logic        out_valid;
    logic [4:0]  out_chan;
    logic [7:0]  out_data;
    logic        ovf_flag;
    logic        unf_flag;

    int checks = 0;
    int errors = 0;

    int got_n;
    int got_ch [64];
    int got_d  [64];
    int exp_n;
    int exp_ch [64];
    int exp_d  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    tslot_pack u_tslot_pack (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_fstart  (in_fstart),
        .in_data    (in_data),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_data   (out_data),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && got_n < 64) begin
            got_ch[got_n] = int'(out_chan);
            got_d[got_n]  = int'(out_data);
            got_n         = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int base, input int s);
        return 8'((base + s * 37) & 255);
    endfunction

    function automatic int live_of(input logic [31:0] m);
        int n = 0;
        for (int i = 0; i < 32; i++) n += (m[i] ? 0 : 1);
        return n;
    endfunction

    task automatic drive_idle();
        in_valid   = 1'b0;
        in_fstart  = 1'b0;
        in_data    = 8'h00;
        mask_we    = 1'b0;
        mask_wdata = 32'h0;
    endtask

    task automatic write_mask(input logic [31:0] m);
        @(negedge clk);
        mask_we    = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        drive_idle();
    endtask

    // Reference: ascending channels for live slots, fill in blanked slots
    task automatic build_model(input logic [31:0] m, input int nslots, input bit with_fs, input int base);
        int k = live_of(m);
        int c = 0;
        int f = 0;
        exp_n = 0;
        if (with_fs) begin
            for (int s = 0; s < nslots && s < 32; s++) begin
                if (!m[s]) begin
                    if (c < 24) begin
                        exp_ch[exp_n] = c; exp_d[exp_n] = int'(dbyte(base, s));
                        exp_n++; c++;
                    end
                end else if (k < 24 && f < 24 - k) begin
                    exp_ch[exp_n] = k + f; exp_d[exp_n] = 255;
                    exp_n++; f++;
                end
            end
        end
    endtask

    task automatic send_frame(input int nslots, input logic [31:0] mdl, input int gap,
                              input int chg_at, input logic [31:0] chg_val, input bit with_fs,
                              input int base, input bit e_ovf, input bit e_unf, input string req);
        int bad;
        build_model(mdl, nslots, with_fs, base);
        got_n = 0;
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_fstart  = with_fs && (s == 0);
            in_data    = dbyte(base, s);
            mask_we    = (s == chg_at);
            mask_wdata = chg_val;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                drive_idle();
            end
        end
        @(negedge clk);
        drive_idle();
        repeat (2) @(negedge clk);
        chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (bad < 0 && (got_ch[i] != exp_ch[i] || got_d[i] != exp_d[i])) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, {req, " sequence chan*256+data"},
                got_ch[bad] * 256 + got_d[bad], exp_ch[bad] * 256 + exp_d[bad]);
        else
            chk(1'b1, req, 0, 0);
        chk(ovf_flag == e_ovf, {req, " ovf_flag"}, int'(ovf_flag), int'(e_ovf));
        chk(unf_flag == e_unf, {req, " unf_flag"}, int'(unf_flag), int'(e_unf));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rm;
        got_n = 0;
        drive_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the ports
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(ovf_flag == 1'b0, "R1 ovf_flag after reset", int'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R1 unf_flag after reset", int'(unf_flag), 0);

        // R2: bytes before the first frame start produce nothing
        send_frame(5, 32'hFF00_0000, 0, -1, 32'h0, 1'b0, 3, 1'b0, 1'b0, "R2 pre-sync");

        // R1: default mask maps slots 0..23 straight through
        send_frame(32, 32'hFF00_0000, 0, -1, 32'h0, 1'b1, 11, 1'b0, 1'b0, "R1 default mask");

        // R3 R4 R6 R7 R8: table of masks
        for (int v = 0; v < NVEC; v++) begin
            write_mask(VEC[v][33:2]);
            send_frame(32, VEC[v][33:2], v % 2, -1, 32'h0, 1'b1, 20 + v,
                       VEC[v][1], VEC[v][0], "R3/R4/R6/R7/R8 table");
        end

        // R5: mid-frame write deferred to next frame
        write_mask(32'h0000_00FF);
        send_frame(32, 32'h0000_00FF, 0, 10, 32'hFFFF_FFFF, 1'b1, 40, 1'b0, 1'b0, "R5 mid-frame write");
        send_frame(32, 32'hFFFF_FFFF, 0, -1, 32'h0, 1'b1, 41, 1'b0, 1'b1, "R5 next frame");

        // R2: bytes after timeslot 31 dropped
        write_mask(32'hFFFF_0000);
        send_frame(36, 32'hFFFF_0000, 0, -1, 32'h0, 1'b1, 50, 1'b0, 1'b1, "R2 long frame");

        // R4: early frame start restarts the channel count
        write_mask(32'h0000_0000);
        send_frame(20, 32'h0000_0000, 0, -1, 32'h0, 1'b1, 60, 1'b1, 1'b0, "R4 short frame");
        send_frame(32, 32'h0000_0000, 1, -1, 32'h0, 1'b1, 61, 1'b1, 1'b0, "R6 after short frame");

        // R9 R3 R7: random masks against the model
        for (int r = 0; r < 12; r++) begin
            rm = $urandom;
            if (r % 3 == 0) rm = rm | 32'hFFFF_0000;
            write_mask(rm);
            send_frame(32, rm, r % 2, -1, 32'h0, 1'b1, 70 + r,
                       live_of(rm) > 24, live_of(rm) < 24, "R9 random mask");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule